// File: doc/BRIEF.md
# Four-Group LED PWM Dimmer with Serial Duty Loading

This block produces six LED dimming enables, bundled as four groups: the first two outputs share group A, the next two share group B, and groups C and D each own one output. A configuration pin picks between two sources for these enables.

In direct mode, four external active-high PWM inputs are resynchronised and drive the four groups one for one. In serial mode, three of those inputs act as a data line, a bit clock and an end-of-frame strobe. A frame of four duty bytes is shifted in and then committed as a whole when the strobe rises. Four internal 8-bit PWM generators then shape the group enables.

The PWM period is 256 steps, and each step lasts `STEP_DIV` system clocks. The integrator sizes `STEP_DIV` so that the period rate stays at or below roughly 488 Hz.

Top module: `led_group_dimmer`

## Requirements
- R1: Outputs 0 and 1 always carry group A, outputs 2 and 3 carry group B, output 4 carries group C and output 5 carries group D.
- R2: In serial mode (`mode_serial` high), `in_a` is the data line, and it is sampled on each rising edge of the bit clock `in_b`, most significant bit first. Of the 32 bits in a frame, bits 31..24 (sent first) are group A's duty, 23..16 are group B's, 15..8 are group C's and 7..0 (sent last) are group D's.
- R3: A rising edge on `in_c` in serial mode commits all four bytes of a 32-bit frame together, and every such edge clears the bit count.
- R4: A duty d below 0xFF holds a group high for exactly d·STEP_DIV system clocks per period. A duty of 0x00 is never high, and 0xFF is high for the entire period.
- R5: The period is 256·STEP_DIV clocks and counts from reset release. New duties take effect only at a period boundary. A commit detected in the very cycle of a boundary applies from that boundary onward.
- R6: After reset, all six outputs are low and all duties are zero.
- R7: In direct mode (`mode_serial` low), each group follows `in_a`..`in_d` (A..D) three system clocks later, with the high time preserved cycle for cycle.
- R8: `in_d` has no effect on any output in serial mode.
- R9: If the end-of-frame edge arrives after fewer or more than 32 bits, the frame is discarded and the duties in use stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_serial | input | 1 | 1 = serial frame mode, 0 = direct mode |
| in_a | input | 1 | Serial data / direct group A |
| in_b | input | 1 | Serial bit clock / direct group B |
| in_c | input | 1 | End-of-frame strobe / direct group C |
| in_d | input | 1 | Direct group D, unused in serial mode |
| grp_en | output | 6 | LED channel enables, bit i = channel i |

## Verification
The end-of-frame commit and the PWM period wrap can land on the same system clock. The bench counts clock edges from reset release and raises the strobe exactly three edges before a boundary, so that its synchronised rising edge is seen in the wrap cycle. Two things are then judged from per-output high-time counts. The period that ends at that boundary must still show the old duties. The period that starts there must already show all four new duties.

// File: rtl/led_group_dimmer.sv
module led_group_dimmer #(
  parameter int STEP_DIV = 4,
  parameter int DUTY_W   = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_serial,
  input  logic       in_a,
  input  logic       in_b,
  input  logic       in_c,
  input  logic       in_d,
  output logic [5:0] grp_en
);
  localparam int NGRP       = 4;
  localparam int FRAME_BITS = NGRP * DUTY_W;
  localparam int CNT_W      = $clog2(FRAME_BITS + 2);
  localparam int PRE_W      = (STEP_DIV > 1) ? $clog2(STEP_DIV) : 1;
  localparam logic [DUTY_W-1:0] FULL     = '1;
  localparam logic [CNT_W-1:0]  CNT_FULL = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0]  CNT_OVER = CNT_W'(FRAME_BITS + 1);

  logic [4:0] meta, syn;
  logic       sclk_d, eof_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      meta <= '0; syn <= '0; sclk_d <= 1'b0; eof_d <= 1'b0;
    end else begin
      meta   <= {mode_serial, in_d, in_c, in_b, in_a};
      syn    <= meta;
      sclk_d <= syn[1];
      eof_d  <= syn[2];
    end

  wire ser       = syn[4];
  wire sclk_rise = ser & syn[1] & ~sclk_d;
  wire eof_rise  = ser & syn[2] & ~eof_d;

  logic [FRAME_BITS-1:0]        shadow;
  logic [CNT_W-1:0]             nbits;
  logic [NGRP-1:0][DUTY_W-1:0]  staged, live;
  wire  frame_ok = eof_rise && (nbits == CNT_FULL);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      shadow <= '0; nbits <= '0; staged <= '0;
    end else if (eof_rise) begin
      nbits <= '0;
      if (frame_ok) staged <= shadow;
    end else if (sclk_rise) begin
      shadow <= {shadow[FRAME_BITS-2:0], syn[0]};
      if (nbits != CNT_OVER) nbits <= nbits + 1'b1;
    end

  logic [PRE_W-1:0]  pre;
  logic [DUTY_W-1:0] step;
  wire pre_last = (pre == PRE_W'(STEP_DIV - 1));
  wire wrap     = pre_last && (step == FULL);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pre <= '0; step <= '0; live <= '0;
    end else begin
      pre <= pre_last ? '0 : pre + 1'b1;
      if (pre_last) step <= step + 1'b1;
      if (wrap) live <= frame_ok ? shadow : staged;
    end

  logic [NGRP-1:0] grp_q;

  for (genvar g = 0; g < NGRP; g++) begin : g_pwm
    wire [DUTY_W-1:0] duty = live[NGRP-1-g];
    wire              pwm  = (duty == FULL) || (step < duty);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) grp_q[g] <= 1'b0;
      else        grp_q[g] <= ser ? pwm : syn[g];

    a_r4_full_on: assert property (@(posedge clk) disable iff (!rst_n)
      (ser && duty == FULL) |=> grp_q[g]);
    a_r4_zero_off: assert property (@(posedge clk) disable iff (!rst_n)
      (ser && duty == '0) |=> !grp_q[g]);
  end

  assign grp_en = {grp_q[3], grp_q[2], grp_q[1], grp_q[1], grp_q[0], grp_q[0]};

  a_r5_swap_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(live));
  a_r9_bad_frame_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (eof_rise && nbits != CNT_FULL) |=> $stable(staged));
  a_r3_count_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    eof_rise |=> (nbits == '0));
  a_r7_direct_follow: assert property (@(posedge clk) disable iff (!rst_n)
    !ser |=> (grp_q == $past(syn[NGRP-1:0])));
endmodule

// File: tb/sim_led_group_dimmer.sv
module sim_led_group_dimmer;
  localparam int DIV = 4;
  localparam int P   = 256 * DIV;

  logic clk = 1'b0, rst_n = 1'b0, mode_serial = 1'b1;
  logic in_a = 1'b0, in_b = 1'b0, in_c = 1'b0, in_d = 1'b0;
  logic [5:0] grp_en;

  always #2.5 clk = ~clk;

  led_group_dimmer #(.STEP_DIV(DIV), .DUTY_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_serial(mode_serial),
    .in_a(in_a), .in_b(in_b), .in_c(in_c), .in_d(in_d), .grp_en(grp_en));

  int nchk = 0, nfail = 0;
  int k = 0;
  always @(posedge clk) if (rst_n) k <= k + 1;

  int    q_w[$], q_a[$], q_b[$], q_c[$], q_d[$];
  string q_tag[$];

  task automatic check(string what, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic int hi(int d);
    return (d == 255) ? P : d * DIV;
  endfunction

  task automatic expect_w(int w, int a, int b, int c, int d, string tag);
    q_w.push_back(w); q_a.push_back(a); q_b.push_back(b);
    q_c.push_back(c); q_d.push_back(d); q_tag.push_back(tag);
  endtask

  int cnt[6];
  int mw;
  always @(negedge clk) begin
    if (rst_n && k > 0) begin
      for (int i = 0; i < 6; i++) if (grp_en[i]) cnt[i]++;
      if (k % P == 0) begin
        mw = k / P - 1;
        while (q_w.size() > 0 && q_w[0] < mw) begin
          check($sformatf("R5 %s window %0d never compared", q_tag[0], q_w[0]), 0, 1);
          void'(q_w.pop_front()); void'(q_a.pop_front()); void'(q_b.pop_front());
          void'(q_c.pop_front()); void'(q_d.pop_front()); void'(q_tag.pop_front());
        end
        if (q_w.size() > 0 && q_w[0] == mw) begin
          for (int i = 0; i < 6; i++) begin
            int e;
            e = (i < 2) ? q_a[0] : (i < 4) ? q_b[0] : (i == 4) ? q_c[0] : q_d[0];
            check($sformatf("R1 %s window %0d ch%0d high-cycles", q_tag[0], mw, i), cnt[i], e);
          end
          void'(q_w.pop_front()); void'(q_a.pop_front()); void'(q_b.pop_front());
          void'(q_c.pop_front()); void'(q_d.pop_front()); void'(q_tag.pop_front());
        end
        for (int i = 0; i < 6; i++) cnt[i] = 0;
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(bit b);
    in_a = b; tick(2); in_b = 1'b1; tick(3); in_b = 1'b0; tick(2);
  endtask

  task automatic send_bits(logic [39:0] v, int n);
    for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic pulse_eof();
    in_c = 1'b1; tick(4); in_c = 1'b0; tick(4);
  endtask

  task automatic wait_window(int w);
    while (k < (w + 1) * P + 1) tick(1);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check("watchdog expired, all requirements unfinished", 0, 1);
    finish_run();
  end

  initial begin
    int w, m;
    tick(3);
    rst_n = 1'b1;
    tick(2);
    check("R6 outputs after reset", int'(grp_en), 0);
    expect_w(0, 0, 0, 0, 0, "R6 zero duty");

    // R8: in_d held high throughout serial mode
    in_d = 1'b1;
    send_bits(40'h40_80_FF_00, 32); pulse_eof();
    w = k / P + 1;
    expect_w(w, hi(8'h40), hi(8'h80), hi(8'hFF), hi(8'h00), "R2 R4 R8 frame1");
    wait_window(w);

    send_bits(40'hFE_01_00_10, 32); pulse_eof();
    w = k / P + 1;
    expect_w(w, hi(8'hFE), hi(8'h01), hi(8'h00), hi(8'h10), "R3 R4 frame2");
    wait_window(w);

    send_bits(40'h11_22_33_44, 31); pulse_eof();
    w = k / P + 2;
    expect_w(w, hi(8'hFE), hi(8'h01), hi(8'h00), hi(8'h10), "R9 short frame");
    wait_window(w);

    send_bits(40'h01_11_22_33_44, 33); pulse_eof();
    w = k / P + 2;
    expect_w(w, hi(8'hFE), hi(8'h01), hi(8'h00), hi(8'h10), "R9 long frame");
    wait_window(w);

    // R5: commit coincides with period boundary (also R3 count cleared)
    m = k / P + 2;
    expect_w(m - 1, hi(8'hFE), hi(8'h01), hi(8'h00), hi(8'h10), "R5 old before boundary");
    expect_w(m, hi(8'h20), hi(8'h30), hi(8'h40), hi(8'h50), "R5 R3 new at boundary");
    send_bits(40'h20_30_40_50, 32);
    while (k < m * P - 3) tick(1);
    in_c = 1'b1; tick(4); in_c = 1'b0;
    wait_window(m);

    // R7: direct mode
    mode_serial = 1'b0;
    in_a = 1'b1; in_b = 1'b0; in_c = 1'b1; in_d = 1'b0;
    tick(10);
    w = k / P + 2;
    expect_w(w, P, 0, P, 0, "R7 static direct");
    wait_window(w);

    w = k / P + 1;
    expect_w(w, P, 300, P, 50, "R7 direct pulses");
    while (k < w * P + 100) tick(1);
    in_b = 1'b1; tick(300); in_b = 1'b0;
    in_d = 1'b1; tick(50);  in_d = 1'b0;
    wait_window(w);

    tick(5);
    check("R5 expectations left unchecked", q_w.size(), 0);
    finish_run();
  end
endmodule